// File: doc/BRIEF.md
# Descriptor Table Register Load/Store Unit

This block keeps two system table registers, one for the global descriptor table and one for the interrupt descriptor table. Each register holds a 16-bit limit and a 32-bit base. It moves either register to or from a six-byte memory image over a byte-wide port, transferring one byte per cycle in ascending offset order. The memory image is the limit followed by the base, and each field is little-endian: offsets 0 and 1 hold limit bits 7:0 and 15:8, and offsets 2 to 5 hold base bits 7:0 up to 31:24.

The two directions treat operand size differently, and this is intended. A load with a 16-bit operand size takes only three base bytes, clears base bits 31:24 and never reads the sixth byte. A store always writes the full 32-bit base, whatever the operand size. Code that only ever loads with 16-bit size therefore always finds a zero top byte. Code that mixes sizes gets back the base it actually loaded. A legacy flag makes a store emit 0xFF in the sixth byte instead of the top base byte.

A command is started by a one-cycle start strobe. The block then reports busy while it drives byte offsets. It pulses done after the last byte. A load's new value appears on the register outputs only in that done cycle.

Top module: `dtr_xfer_unit`

## Requirements
- R1: After reset both registers read base 0x00000000 and limit 0xFFFF, and busy_o and done_o are low.
- R2: A start accepted while idle raises busy_o on the next cycle. While busy, offs_o steps 0,1,2,… one per cycle. A store and a 32-bit load (op32_i=1) take 6 cycles. A 16-bit load (op32_i=0) takes 5 cycles and stops at offset 4.
- R3: A 32-bit load sets limit = {byte1,byte0} and base = {byte5,byte4,byte3,byte2}, where byte n is rd_data_i sampled at offset n.
- R4: A 16-bit load sets limit = {byte1,byte0} and base = {8'h00,byte4,byte3,byte2}. The byte at offset 5 is never addressed.
- R5: A store (store_i=1) with legacy_i=0 asserts wr_en_o on every busy cycle and writes limit bits 7:0, 15:8, then base bits 7:0, 15:8, 23:16, 31:24 at offsets 0 to 5, for either value of op32_i.
- R6: A store with legacy_i=1 writes 0xFF at offset 5; offsets 0 to 4 are as in R5.
- R7: Register outputs do not change while busy_o is high. A load's result is first visible in the cycle where done_o is high.
- R8: done_o is high for exactly one cycle, the cycle after the last byte, with busy_o low in that cycle.
- R9: start_i and the command inputs are ignored while busy_o is high.
- R10: sel_i=0 addresses the global table register and sel_i=1 the interrupt table register. The register not selected is left unchanged by a load.
- R11: A load never asserts wr_en_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only while idle |
| store_i | input | 1 | 1 = store register to memory, 0 = load from memory |
| sel_i | input | 1 | 0 = global table, 1 = interrupt table |
| op32_i | input | 1 | 1 = 32-bit operand size, 0 = 16-bit |
| legacy_i | input | 1 | Store writes 0xFF in the sixth byte |
| rd_data_i | input | 8 | Memory read byte for the current offset |
| offs_o | output | 3 | Byte offset in the six-byte image |
| wr_data_o | output | 8 | Store byte |
| wr_en_o | output | 1 | Write enable for wr_data_o |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| gt_base_o | output | 32 | Global table base |
| gt_limit_o | output | 16 | Global table limit |
| it_base_o | output | 32 | Interrupt table base |
| it_limit_o | output | 16 | Interrupt table limit |

## Verification
A wrong byte counter shows at once on offs_o in the same busy cycle. It also shows up later as a wrong transfer length: a 16-bit load that touches offset 5, or a done pulse one cycle early or late. A corrupted capture buffer or a wrong size mask stays hidden until the done cycle, when the register outputs take a wrong value. It can also surface at the next store of that table, where wr_data_o carries the bad byte at its offset. Storing a base with bit 31 set using a 16-bit operand size shows within six cycles whether the store path wrongly truncates to 24 bits.

// File: rtl/dtr_pkg.sv
package dtr_pkg;
  localparam int BASE_W           = 32;
  localparam int LIM_W            = 16;
  localparam int BYTE_W           = 8;
  localparam int NUM_TBL          = 2;
  localparam int LIM_BYTES        = LIM_W / BYTE_W;
  localparam int BASE_BYTES       = BASE_W / BYTE_W;
  localparam int IMG_BYTES        = LIM_BYTES + BASE_BYTES;
  localparam int IMG_BITS         = IMG_BYTES * BYTE_W;
  localparam int SHORT_BASE_BYTES = 3;
  localparam int SHORT_IMG_BYTES  = LIM_BYTES + SHORT_BASE_BYTES;
  localparam int CNT_W            = $clog2(IMG_BYTES);
  localparam int SEL_W            = (NUM_TBL > 1) ? $clog2(NUM_TBL) : 1;

  // packed so that the flat vector equals the little-endian memory image
  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [LIM_W-1:0]  limit;
  } dtr_t;

  typedef struct packed {
    logic             store;
    logic [SEL_W-1:0] sel;
    logic             op32;
    logic             legacy;
  } ctl_t;
endpackage

// File: rtl/dtr_rst_sync.sv
module dtr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/dtr_seq.sv
module dtr_seq
  import dtr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  ctl_t             cmd_i,
  output ctl_t             ctl_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             busy_o,
  output logic             last_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(IMG_BYTES - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_IMG_BYTES - 1);

  ctl_t             ctl_q, ctl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] last_idx;
  logic             last;
  logic             accept;

  assign last_idx = (!ctl_q.store && !ctl_q.op32) ? LAST_SHORT : LAST_LONG;
  assign last     = busy_q && (cnt_q == last_idx);
  assign accept   = start_i && !busy_q;

  always_comb begin
    ctl_d  = ctl_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (accept) begin
      ctl_d  = cmd_i;
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (last) begin
      cnt_d  = '0;
      busy_d = 1'b0;
      done_d = 1'b1;
    end else if (busy_q) begin
      cnt_d  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ctl_q  <= ctl_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign ctl_o  = ctl_q;
  assign cnt_o  = cnt_q;
  assign busy_o = busy_q;
  assign last_o = last;
  assign done_o = done_q;

  // R2: offsets step by one while a transfer runs
  a_r2_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last) |=> (busy_q && cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R2: a short load never reaches the sixth byte
  a_r2_short_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ctl_q.store && !ctl_q.op32) |-> (cnt_q <= LAST_SHORT));

  // R8: done follows the last byte, with busy already low
  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (done_q && !busy_q));

  // R8: done lasts one cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R9: the latched command holds while busy
  a_r9_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last) |=> $stable(ctl_q));
endmodule

// File: rtl/dtr_load_asm.sv
module dtr_load_asm
  import dtr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  input  logic              op32_i,
  output dtr_t              img_o
);
  logic [IMG_BITS-1:0] shadow_q, shadow_d;
  logic [IMG_BITS-1:0] merged;

  always_comb begin
    shadow_d = shadow_q;
    if (cap_en_i) shadow_d[cnt_i*BYTE_W +: BYTE_W] = rd_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow_q <= '0;
    else        shadow_q <= shadow_d;
  end

  // image as it will be on commit: captured bytes plus the byte on the bus now
  always_comb begin
    merged = shadow_d;
    for (int i = SHORT_IMG_BYTES; i < IMG_BYTES; i++) begin
      if (!op32_i) merged[i*BYTE_W +: BYTE_W] = '0;
    end
  end

  assign img_o = dtr_t'(merged);
endmodule

// File: rtl/dtr_regfile.sv
module dtr_regfile
  import dtr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_i,
  input  logic [SEL_W-1:0] wsel_i,
  input  dtr_t             wdata_i,
  input  logic [SEL_W-1:0] rsel_i,
  output dtr_t             rdata_o,
  output dtr_t             tbl_o [NUM_TBL]
);
  dtr_t tbl_q [NUM_TBL];

  for (genvar g = 0; g < NUM_TBL; g++) begin : g_tbl
    logic wen;
    assign wen = commit_i && (wsel_i == SEL_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tbl_q[g].base  <= '0;
        tbl_q[g].limit <= '1;
      end else if (wen) begin
        tbl_q[g] <= wdata_i;
      end
    end

    assign tbl_o[g] = tbl_q[g];

    // R10: the unselected register keeps its value across a commit
    a_r10_other_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_i && wsel_i != SEL_W'(g)) |=> $stable(tbl_q[g]));

    // R7: no change without a commit
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_i |=> $stable(tbl_q[g]));
  end

  assign rdata_o = tbl_q[rsel_i];
endmodule

// File: rtl/dtr_store_mux.sv
module dtr_store_mux
  import dtr_pkg::*;
(
  input  dtr_t              src_i,
  input  logic              legacy_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [BYTE_W-1:0] wr_data_o
);
  logic [IMG_BITS-1:0] img;

  always_comb begin
    img = src_i;
    if (legacy_i) img[IMG_BITS-1 -: BYTE_W] = '1;
  end

  assign wr_data_o = img[cnt_i*BYTE_W +: BYTE_W];
endmodule

// File: rtl/dtr_xfer_unit.sv
module dtr_xfer_unit
  import dtr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        store_i,
  input  logic        sel_i,
  input  logic        op32_i,
  input  logic        legacy_i,
  input  logic [7:0]  rd_data_i,
  output logic [2:0]  offs_o,
  output logic [7:0]  wr_data_o,
  output logic        wr_en_o,
  output logic        busy_o,
  output logic        done_o,
  output logic [31:0] gt_base_o,
  output logic [15:0] gt_limit_o,
  output logic [31:0] it_base_o,
  output logic [15:0] it_limit_o
);
  logic             rst_n_s;
  ctl_t             cmd, ctl;
  logic [CNT_W-1:0] cnt;
  logic             busy, last, done;
  dtr_t             load_img, rd_tbl;
  dtr_t             tbl [NUM_TBL];

  assign cmd = '{store: store_i, sel: SEL_W'(sel_i), op32: op32_i, legacy: legacy_i};

  dtr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  dtr_seq u_seq (
    .clk(clk), .rst_n(rst_n_s), .start_i(start_i), .cmd_i(cmd),
    .ctl_o(ctl), .cnt_o(cnt), .busy_o(busy), .last_o(last), .done_o(done)
  );

  dtr_load_asm u_asm (
    .clk(clk), .rst_n(rst_n_s), .cap_en_i(busy && !ctl.store), .cnt_i(cnt),
    .rd_data_i(rd_data_i), .op32_i(ctl.op32), .img_o(load_img)
  );

  dtr_regfile u_rf (
    .clk(clk), .rst_n(rst_n_s), .commit_i(last && !ctl.store), .wsel_i(ctl.sel),
    .wdata_i(load_img), .rsel_i(ctl.sel), .rdata_o(rd_tbl), .tbl_o(tbl)
  );

  dtr_store_mux u_mux (
    .src_i(rd_tbl), .legacy_i(ctl.legacy), .cnt_i(cnt), .wr_data_o(wr_data_o)
  );

  assign offs_o     = 3'(cnt);
  assign wr_en_o    = busy && ctl.store;
  assign busy_o     = busy;
  assign done_o     = done;
  assign gt_base_o  = tbl[0].base;
  assign gt_limit_o = tbl[0].limit;
  assign it_base_o  = tbl[1].base;
  assign it_limit_o = tbl[1].limit;

  // R11: writes only happen during a transfer
  a_r11_wr_in_busy: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_en_o |-> busy_o);

  // R8: done and busy never overlap
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |-> !busy_o);

  // R1: idle after reset release
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rst_n_s) |-> (!busy_o && !done_o));
endmodule

// File: tb/sim_dtr_xfer_unit.sv
`timescale 1ns/100ps
module sim_dtr_xfer_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, store_i, sel_i, op32_i, legacy_i;
  logic [7:0]  rd_data_i;
  logic [2:0]  offs_o;
  logic [7:0]  wr_data_o;
  logic        wr_en_o, busy_o, done_o;
  logic [31:0] gt_base_o, it_base_o;
  logic [15:0] gt_limit_o, it_limit_o;

  logic [7:0]  mem [8];
  logic [31:0] m_base [2];
  logic [15:0] m_lim  [2];
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  assign rd_data_i = mem[offs_o];

  dtr_xfer_unit u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .store_i(store_i), .sel_i(sel_i),
    .op32_i(op32_i), .legacy_i(legacy_i), .rd_data_i(rd_data_i), .offs_o(offs_o),
    .wr_data_o(wr_data_o), .wr_en_o(wr_en_o), .busy_o(busy_o), .done_o(done_o),
    .gt_base_o(gt_base_o), .gt_limit_o(gt_limit_o),
    .it_base_o(it_base_o), .it_limit_o(it_limit_o)
  );

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] exp_store(input logic sel, input logic leg);
    logic [47:0] img;
    img = {m_base[sel], m_lim[sel]};
    if (leg) img[47:40] = 8'hFF;
    return img;
  endfunction

  function automatic logic [47:0] exp_load(input logic op32);
    logic [31:0] b;
    b = op32 ? {mem[5], mem[4], mem[3], mem[2]} : {8'h00, mem[4], mem[3], mem[2]};
    return {b, mem[1], mem[0]};
  endfunction

  task automatic check_regs(input string req);
    check({gt_base_o, gt_limit_o} == {m_base[0], m_lim[0]}, req,
          {16'h0, gt_base_o, gt_limit_o}, {16'h0, m_base[0], m_lim[0]});
    check({it_base_o, it_limit_o} == {m_base[1], m_lim[1]}, req,
          {16'h0, it_base_o, it_limit_o}, {16'h0, m_base[1], m_lim[1]});
  endtask

  task automatic run_op(input logic st, input logic sel, input logic op32,
                        input logic leg, input logic hold);
    int          n, k;
    logic [47:0] pre_g, pre_i, got, exp;
    n     = (st || op32) ? 6 : 5;
    pre_g = {gt_base_o, gt_limit_o};
    pre_i = {it_base_o, it_limit_o};
    got   = '0;
    @(negedge clk);
    start_i = 1'b1; store_i = st; sel_i = sel; op32_i = op32; legacy_i = leg;
    @(negedge clk);
    if (hold) begin
      store_i = ~st; sel_i = ~sel; op32_i = ~op32; legacy_i = ~leg;
    end else begin
      start_i = 1'b0;
    end
    k = 0;
    while (busy_o && k < 10) begin
      check(offs_o == 3'(k), "R2 offset", {61'h0, offs_o}, 64'(k));
      check(wr_en_o == st, st ? "R5 write enable" : "R11 no write on load",
            {63'h0, wr_en_o}, {63'h0, st});
      if (wr_en_o && k < 6) got[k*8 +: 8] = wr_data_o;
      check({gt_base_o, gt_limit_o} == pre_g && {it_base_o, it_limit_o} == pre_i,
            "R7 no early update", {16'h0, gt_base_o, gt_limit_o}, {16'h0, pre_g});
      k++;
      if (k == 2) start_i = 1'b0;
      @(negedge clk);
    end
    check(k == n, hold ? "R9 start ignored, length" : "R2 length", 64'(k), 64'(n));
    check(done_o && !busy_o, "R8 done after last", {62'h0, done_o, busy_o}, 64'h2);
    if (st) begin
      exp = exp_store(sel, leg);
      check(got == exp, leg ? "R6 legacy store image" : "R5 store image",
            {16'h0, got}, {16'h0, exp});
    end else begin
      exp = exp_load(op32);
      m_base[sel] = exp[47:16];
      m_lim[sel]  = exp[15:0];
      check_regs(op32 ? "R3 R10 load32" : "R4 R10 load16");
    end
    @(negedge clk);
    check(!done_o, "R8 single pulse", {63'h0, done_o}, 64'h0);
  endtask

  task automatic fill_mem(input logic [47:0] img);
    for (int i = 0; i < 6; i++) mem[i] = img[i*8 +: 8];
    mem[6] = 8'h00; mem[7] = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; start_i = 1'b0; store_i = 1'b0; sel_i = 1'b0; op32_i = 1'b0; legacy_i = 1'b0;
    fill_mem(48'h0);
    m_base[0] = '0; m_base[1] = '0; m_lim[0] = 16'hFFFF; m_lim[1] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(!busy_o && !done_o, "R1 idle", {62'h0, busy_o, done_o}, 64'h0);
    check_regs("R1 reset value");

    // R3: 32-bit load of a base with top bits set into the global table
    fill_mem(48'h8123_4567_BEEF);
    run_op(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    // R5: 16-bit store still carries the full base, top byte 0x81
    run_op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    // R4: 16-bit load into interrupt table, sixth byte nonzero but dropped
    fill_mem(48'hAA55_6677_1234);
    run_op(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check(it_base_o[31:24] == 8'h00, "R4 top byte zero", {56'h0, it_base_o[31:24]}, 64'h0);
    // R5 32-bit store, R6 legacy store
    run_op(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    run_op(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    // R9: start held high with altered fields during a load
    fill_mem(48'hFEDC_BA98_7654);
    run_op(1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    run_op(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);

    for (int r = 0; r < 80; r++) begin
      logic [31:0] ra, rb;
      ra = $urandom; rb = $urandom;
      fill_mem({ra, rb[15:0]});
      run_op(ra[0] ^ rb[31], rb[30], rb[29], rb[28], rb[27] & rb[26]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule